// File: doc/BRIEF.md
# Dual half-period PWM timer

This block produces a square-wave style PWM signal from a single 16-bit compare word. The low byte of the word gives the length of the first output phase and the high byte gives the length of the second phase, each as a reload count for an 8-bit down-counter. The phase time is therefore the byte value plus one. The full period is the sum of the two phase times. It spans 2 to 512 clock counts, so the output frequency lies between clk/512 and clk/2.

A 2-bit mode field controls the timer. Writing the run code starts the timer with the output in its first phase. Any other code stops it and returns the pin to its idle level. The compare word may be rewritten at any time, but the counter only reads it at a phase reload. The usual way to change frequency is to stop, rewrite and restart. A polarity input selects whether the pin carries the timer output directly or inverted.

Top module: `dual_pwm_timer`

## Requirements
- R1: After reset, with the mode field at 2'b00 and inv_i=0, pwm_o is 0.
- R2: Mode code 2'b10 runs the timer. On the first clock edge that sees this code after a stop or reset, the timer output goes to 1 (pwm_o=1 when inv_i=0).
- R3: The first phase, timer output 1, lasts cmp_i[7:0]+1 clock cycles.
- R4: The second phase, timer output 0, lasts cmp_i[15:8]+1 clock cycles.
- R5: The phases alternate with no dead cycle between them. Compare 0x0000 gives a 1+1 cycle period and 0xFFFF gives a 256+256 cycle period.
- R6: Any mode code other than 2'b10 stops the timer. From the next clock edge the timer output is 0 and pwm_o holds the idle level inv_i. Code 2'b01 counts as a stop.
- R7: A restart after a stop begins a new first phase of cmp_i[7:0]+1 cycles, using the compare value present at restart.
- R8: A compare change while running does not alter the phase in progress. It takes effect at the next phase reload.
- R9: With inv_i=1 the pin is the inverse of the timer output: low during the first phase and high while stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Timer clock; the counter steps once per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmp_i | input | 16 | Compare word: [7:0] first-phase reload, [15:8] second-phase reload |
| mode_i | input | 2 | Mode field: 2'b10 runs, any other value stops |
| inv_i | input | 1 | Pin polarity: 0 active-high, 1 active-low |
| pwm_o | output | 1 | PWM output pin |

## Verification
The bench uses the default 8-bit counter width, so the whole compare space fits in one word. The extremes 0x0000 and 0xFFFF reach both the shortest 2-cycle period and the longest 512-cycle period. Asymmetric words such as 0x0305 show that each byte steers its own phase. A compare rewrite in the middle of a phase shows that the new value waits for the next reload.

// File: rtl/dual_pwm_pkg.sv
package dual_pwm_pkg;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned MODE_W = 2;
  localparam logic [MODE_W-1:0] MODE_DUAL8 = 2'b10;
endpackage

// File: rtl/dual_pwm_ctrl.sv
module dual_pwm_ctrl
  import dual_pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  output logic              start_o,
  output logic              active_o,
  output logic              run_q_o
);
  logic run_q;
  logic run_req;

  assign run_req  = (mode_i == MODE_DUAL8);
  assign start_o  = run_req && !run_q;
  assign active_o = run_req && run_q;
  assign run_q_o  = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= run_req;
  end
endmodule

// File: rtl/dual_pwm_counter.sv
module dual_pwm_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         active_i,
  input  logic         level_i,
  input  logic [W-1:0] rld_first_i,
  input  logic [W-1:0] rld_second_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= rld_first_i;
    end else if (active_i) begin
      // reload for the phase that follows the one ending now
      if (zero_o) cnt_q <= level_i ? rld_second_i : rld_first_i;
      else        cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/dual_pwm_output.sv
module dual_pwm_output (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic active_i,
  input  logic zero_i,
  input  logic inv_i,
  output logic level_o,
  output logic pin_o
);
  logic level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                level_q <= 1'b0;
    else if (start_i)           level_q <= 1'b1;
    else if (active_i && zero_i) level_q <= ~level_q;
    else if (!active_i)         level_q <= 1'b0;
  end

  assign level_o = level_q;
  assign pin_o   = level_q ^ inv_i;
endmodule

// File: rtl/dual_pwm_timer.sv
module dual_pwm_timer
  import dual_pwm_pkg::*;
#(
  parameter int unsigned HALF_W = CNT_W,
  localparam int unsigned CMP_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CMP_W-1:0]  cmp_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              inv_i,
  output logic              pwm_o
);
  logic              start, active, run_q, zero, level;
  logic [HALF_W-1:0] cnt;

  dual_pwm_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode_i),
    .start_o  (start),
    .active_o (active),
    .run_q_o  (run_q)
  );

  dual_pwm_counter #(.W(HALF_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .active_i     (active),
    .level_i      (level),
    .rld_first_i  (cmp_i[HALF_W-1:0]),
    .rld_second_i (cmp_i[CMP_W-1:HALF_W]),
    .cnt_o        (cnt),
    .zero_o       (zero)
  );

  dual_pwm_output u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .active_i (active),
    .zero_i   (zero),
    .inv_i    (inv_i),
    .level_o  (level),
    .pin_o    (pwm_o)
  );
endmodule

// File: rtl/dual_pwm_timer_chk.sv
module dual_pwm_timer_chk
  import dual_pwm_pkg::*;
#(
  parameter int unsigned HALF_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [2*HALF_W-1:0] cmp_i,
  input logic [MODE_W-1:0]   mode_i,
  input logic                inv_i,
  input logic                pwm_o,
  input logic                run_q,
  input logic                level,
  input logic [HALF_W-1:0]   cnt
);
  logic runs;
  assign runs = (mode_i == MODE_DUAL8) && run_q;

  assert_start_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == MODE_DUAL8) && !run_q) |=> level);

  assert_stop_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_DUAL8) |=> (pwm_o == inv_i));

  assert_hold_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (runs && cnt != '0) |=> $stable(level));

  assert_step_down_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (runs && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  assert_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (runs && cnt == '0 && level) |=> (cnt == $past(cmp_i[2*HALF_W-1:HALF_W]) && !level));
endmodule

bind dual_pwm_timer dual_pwm_timer_chk #(.HALF_W(HALF_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cmp_i  (cmp_i),
  .mode_i (mode_i),
  .inv_i  (inv_i),
  .pwm_o  (pwm_o),
  .run_q  (run_q),
  .level  (level),
  .cnt    (cnt)
);

// File: tb/dual_pwm_timer_bench.sv
module dual_pwm_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cmp = 16'h0000;
  logic [1:0]  mode = 2'b00;
  logic        inv = 1'b0;
  logic        pwm;
  int          n_chk = 0;
  int          n_bad = 0;
  int          cyc = 0;

  always #2.5 clk = ~clk;

  dual_pwm_timer u_dual_pwm_timer (
    .clk_i (clk), .rst_ni (rst_n), .cmp_i (cmp),
    .mode_i (mode), .inv_i (inv), .pwm_o (pwm)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // count negedge samples while pwm == lvl; optionally rewrite cmp after chg_at samples
  task automatic run_len(input logic lvl, output int n,
                         input int chg_at = -1, input logic [15:0] chg_val = 16'h0);
    n = 0;
    while (pwm == lvl && n < 1000) begin
      n++;
      if (n == chg_at) cmp = chg_val;
      @(negedge clk);
    end
  endtask

  task automatic stop_timer();
    mode = 2'b00;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic test_reset();
    check("R1 reset pin", int'(pwm), 0);
  endtask

  task automatic test_word(input logic [15:0] w);
    int a;
    cmp  = w;
    mode = 2'b10;
    @(negedge clk);
    check("R2 starts high", int'(pwm), 1);
    run_len(1'b1, a); check("R3 first phase", a, int'(w[7:0]) + 1);
    run_len(1'b0, a); check("R4 second phase", a, int'(w[15:8]) + 1);
    run_len(1'b1, a); check("R5 steady first phase", a, int'(w[7:0]) + 1);
    run_len(1'b0, a); check("R5 steady second phase", a, int'(w[15:8]) + 1);
    stop_timer();
  endtask

  task automatic test_stop_restart();
    int a;
    cmp = 16'h0707; mode = 2'b10;
    repeat (4) @(negedge clk);
    mode = 2'b01;
    @(negedge clk);
    check("R6 stop by code 01", int'(pwm), 0);
    cmp = 16'h0102;
    repeat (20) @(negedge clk);
    check("R6 idle held", int'(pwm), 0);
    mode = 2'b10;
    @(negedge clk);
    run_len(1'b1, a); check("R7 restart first phase", a, 3);
    run_len(1'b0, a); check("R7 restart second phase", a, 2);
    // stop during second phase
    run_len(1'b1, a);
    mode = 2'b00;
    @(negedge clk);
    check("R6 stop mid low phase", int'(pwm), 0);
    mode = 2'b10;
    @(negedge clk);
    run_len(1'b1, a); check("R7 restart reloads first byte", a, 3);
    stop_timer();
  endtask

  task automatic test_live_update();
    int a;
    cmp = 16'h0404; mode = 2'b10;
    @(negedge clk);
    run_len(1'b1, a, 2, 16'h0101); check("R8 phase in progress kept", a, 5);
    run_len(1'b0, a); check("R8 new second byte used", a, 2);
    run_len(1'b1, a); check("R8 new first byte used", a, 2);
    stop_timer();
  endtask

  task automatic test_invert();
    int a;
    inv = 1'b1;
    @(negedge clk);
    check("R9 idle inverted", int'(pwm), 1);
    cmp = 16'h0201; mode = 2'b10;
    @(negedge clk);
    check("R9 first phase low", int'(pwm), 0);
    run_len(1'b0, a); check("R9 first phase length", a, 2);
    run_len(1'b1, a); check("R9 second phase length", a, 3);
    stop_timer();
    check("R9 stopped high", int'(pwm), 1);
    inv = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_word(16'h0000);
    test_word(16'hFFFF);
    test_word(16'h0305);
    test_word(16'hA017);
    test_stop_restart();
    test_live_update();
    test_invert();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule